// File: doc/BRIEF.md
# Five-Port Dimension-Order Mesh Router

This block is the switching element of one node in a two-dimensional mesh. It has five ports: the local processor and the four neighbours, North, East, South and West. Each port has an inbound request/acknowledge pair, an outbound request/acknowledge pair and a data bus. All handshakes are four-phase. A message is a single data word whose low bits carry the destination coordinates. The router holds each inbound word in a one-word buffer and decides where it goes. A round-robin arbiter at each outbound port then hands the word on.

Routing is strict dimension order, which keeps the network free of deadlock. A word first moves East or West until its x coordinate equals the node's own x. It then moves North or South until y also matches. When both match, it is delivered to the local processor port. For example, a word sent from (1,0) to (2,3) passes through (2,0), (2,1) and (2,2) before it arrives. The node's own coordinates are parameters. The default suits a 4x4 mesh with 2-bit coordinates.

Top module: `mesh_xy_router`

## Requirements
- R1: After reset, every `in_ack` bit and every `out_req` bit is low.
- R2: Port bit index p of every per-port vector means 0 = local processor, 1 = North, 2 = East, 3 = South, 4 = West. A word's destination x is data bits [COORD_W-1:0] and its destination y is bits [2*COORD_W-1:COORD_W]. A word whose destination x is greater than OWN_X leaves on East.
- R3: A word whose destination x is less than OWN_X leaves on West.
- R4: A word whose destination x equals OWN_X and whose destination y is greater than OWN_Y leaves on North.
- R5: A word whose destination x equals OWN_X and whose destination y is less than OWN_Y leaves on South.
- R6: A word whose destination equals (OWN_X, OWN_Y) leaves on the local processor port.
- R7: An inbound port with an empty buffer raises `in_ack` one clock after it sees `in_req` high. It holds `in_ack` while `in_req` stays high, and drops it one clock after `in_req` falls.
- R8: When the chosen outbound port is idle, its `out_req` rises two clocks after `in_req`. The data on it equals the captured word and stays stable while `out_req` is high.
- R9: `out_req` falls one clock after `out_ack` is seen high. It does not rise again while `out_ack` is still high.
- R10: Inputs contending for one outbound port are served in round-robin order. The search starts at the index after the last input served, and port 0 has first priority after reset.
- R11: While an inbound port's buffer holds an undelivered word, a new `in_req` on that port is not acknowledged. It is acknowledged once the held word has been handed off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | NP | Inbound request, one bit per port |
| in_ack | output | NP | Inbound acknowledge, one bit per port |
| in_data | input | NP*DATA_W | Inbound words, port p in bits [p*DATA_W +: DATA_W] |
| out_req | output | NP | Outbound request, one bit per port |
| out_ack | input | NP | Outbound acknowledge, one bit per port |
| out_data | output | NP*DATA_W | Outbound words, port p in bits [p*DATA_W +: DATA_W] |

## Verification
Each handshake result is due a fixed number of edges after its stimulus:
- The inbound acknowledge rises one edge after the request and falls one edge after the request drops.
- The outbound request on an idle port rises two edges after the inbound request, one for capture and one for arbitration.
- The outbound request drops one edge after its acknowledge.

The bench drives all inputs on falling edges and checks each result on the falling edge where it is due. Contention and back-pressure cases use bounded waits, because their order, not their exact cycle, is what is being checked. A sweep sends every destination of the 4x4 mesh from each of the five inputs.

// File: rtl/mesh_rt_pkg.sv
// Package: shared port indices and state encoding for the mesh router.
// Assumes five ports; the index order is the bit order of every port vector.
package mesh_rt_pkg;
    localparam int NUM_PORTS  = 5;
    localparam int DIR_W      = 3;
    localparam int PORT_LOCAL = 0;
    localparam int PORT_NORTH = 1;
    localparam int PORT_EAST  = 2;
    localparam int PORT_SOUTH = 3;
    localparam int PORT_WEST  = 4;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_SEND,
        OUT_RELEASE
    } out_state_t;
endpackage

// File: rtl/mesh_in_port.sv
// Inbound port controller: four-phase receiver with a one-word buffer and
// XY route decode. Assumes the sender holds data stable while req is high.
module mesh_in_port #(
    parameter int DATA_W  = 8,
    parameter int COORD_W = 2,
    parameter int OWN_X   = 1,
    parameter int OWN_Y   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_req,
    output logic                           in_ack,
    input  logic [DATA_W-1:0]              in_data,
    input  logic                           done,
    output logic                           full,
    output logic [DATA_W-1:0]              word,
    output logic [mesh_rt_pkg::DIR_W-1:0]  dir
);
    import mesh_rt_pkg::*;

    localparam logic [COORD_W-1:0] MY_X = COORD_W'(OWN_X);
    localparam logic [COORD_W-1:0] MY_Y = COORD_W'(OWN_Y);

    logic [COORD_W-1:0] dest_x;
    logic [COORD_W-1:0] dest_y;

    assign dest_x = word[COORD_W-1:0];
    assign dest_y = word[2*COORD_W-1:COORD_W];

    // Capture a word when empty; release ack on req low; empty on hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ack <= 1'b0;
            full   <= 1'b0;
            word   <= '0;
        end else if (in_req && !in_ack && !full) begin
            in_ack <= 1'b1;
            full   <= 1'b1;
            word   <= in_data;
        end else begin
            if (in_ack && !in_req) in_ack <= 1'b0;
            if (done)              full   <= 1'b0;
        end
    end

    // Dimension-order decode: x first, then y, else local delivery.
    always_comb begin
        if (dest_x > MY_X)      dir = DIR_W'(PORT_EAST);
        else if (dest_x < MY_X) dir = DIR_W'(PORT_WEST);
        else if (dest_y > MY_Y) dir = DIR_W'(PORT_NORTH);
        else if (dest_y < MY_Y) dir = DIR_W'(PORT_SOUTH);
        else                    dir = DIR_W'(PORT_LOCAL);
    end
endmodule

// File: rtl/mesh_out_port.sv
// Outbound port controller: round-robin arbiter over the inbound buffers
// plus a four-phase sender. Assumes each want bit stays high until done.
module mesh_out_port #(
    parameter int DATA_W = 8,
    parameter int NP     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NP-1:0]              want,
    input  logic [NP-1:0][DATA_W-1:0]  words,
    output logic                       out_req,
    input  logic                       out_ack,
    output logic [DATA_W-1:0]          out_data,
    output logic [NP-1:0]              done
);
    import mesh_rt_pkg::*;

    localparam int IDX_W = $clog2(NP);

    out_state_t       state;
    logic [IDX_W-1:0] owner;
    logic [IDX_W-1:0] last;
    logic [IDX_W-1:0] pick;
    logic             found;

    // Round-robin search starting just after the last input served.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = 1; k <= NP; k++) begin
            int idx;
            idx = (int'(last) + k) % NP;
            if (!found && want[idx]) begin
                found = 1'b1;
                pick  = IDX_W'(idx);
            end
        end
    end

    // Grant, send, then wait for ack to return low before the next grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= OUT_IDLE;
            owner    <= '0;
            last     <= IDX_W'(NP - 1);
            out_data <= '0;
        end else begin
            case (state)
                OUT_IDLE: if (found) begin
                    owner    <= pick;
                    last     <= pick;
                    out_data <= words[pick];
                    state    <= OUT_SEND;
                end
                OUT_SEND:    if (out_ack)  state <= OUT_RELEASE;
                OUT_RELEASE: if (!out_ack) state <= OUT_IDLE;
                default:     state <= OUT_IDLE;
            endcase
        end
    end

    assign out_req = (state == OUT_SEND);

    // One-hot hand-off pulse to the owning input when ack arrives.
    always_comb begin
        done = '0;
        if (state == OUT_SEND && out_ack) done[owner] = 1'b1;
    end
endmodule

// File: rtl/mesh_xy_router.sv
// Top level: five inbound controllers feeding five outbound arbiters.
// Assumes single-word messages with the destination in the low data bits.
module mesh_xy_router #(
    parameter int DATA_W  = 8,
    parameter int COORD_W = 2,
    parameter int OWN_X   = 1,
    parameter int OWN_Y   = 2,
    parameter int NP      = mesh_rt_pkg::NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        in_req,
    output logic [NP-1:0]        in_ack,
    input  logic [NP*DATA_W-1:0] in_data,
    output logic [NP-1:0]        out_req,
    input  logic [NP-1:0]        out_ack,
    output logic [NP*DATA_W-1:0] out_data
);
    import mesh_rt_pkg::*;

    logic [NP-1:0]              in_full;
    logic [NP-1:0]              in_done;
    logic [NP-1:0][DATA_W-1:0]  in_word;
    logic [NP-1:0][DIR_W-1:0]   in_dir;
    logic [NP-1:0][NP-1:0]      done_mat;

    genvar gi;
    generate
        for (gi = 0; gi < NP; gi++) begin : g_in
            mesh_in_port #(
                .DATA_W (DATA_W),
                .COORD_W(COORD_W),
                .OWN_X  (OWN_X),
                .OWN_Y  (OWN_Y)
            ) u_in (
                .clk    (clk),
                .rst_n  (rst_n),
                .in_req (in_req[gi]),
                .in_ack (in_ack[gi]),
                .in_data(in_data[gi*DATA_W +: DATA_W]),
                .done   (in_done[gi]),
                .full   (in_full[gi]),
                .word   (in_word[gi]),
                .dir    (in_dir[gi])
            );
        end

        for (gi = 0; gi < NP; gi++) begin : g_out
            logic [NP-1:0] want;

            // Inputs holding a word routed to this output.
            always_comb begin
                for (int i = 0; i < NP; i++)
                    want[i] = in_full[i] && (in_dir[i] == DIR_W'(gi));
            end

            mesh_out_port #(
                .DATA_W(DATA_W),
                .NP    (NP)
            ) u_out (
                .clk     (clk),
                .rst_n   (rst_n),
                .want    (want),
                .words   (in_word),
                .out_req (out_req[gi]),
                .out_ack (out_ack[gi]),
                .out_data(out_data[gi*DATA_W +: DATA_W]),
                .done    (done_mat[gi])
            );
        end
    endgenerate

    // Merge hand-off pulses from all outputs back to each input.
    always_comb begin
        in_done = '0;
        for (int o = 0; o < NP; o++) in_done |= done_mat[o];
    end
endmodule

// File: rtl/mesh_xy_router_checker.sv
// Checker: handshake and routing properties observed at the router's ports.
module mesh_xy_router_checker #(
    parameter int DATA_W  = 8,
    parameter int COORD_W = 2,
    parameter int OWN_X   = 1,
    parameter int OWN_Y   = 2,
    parameter int NP      = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NP-1:0]        in_req,
    input logic [NP-1:0]        in_ack,
    input logic [NP-1:0]        out_req,
    input logic [NP-1:0]        out_ack,
    input logic [NP*DATA_W-1:0] out_data
);
    import mesh_rt_pkg::*;

    localparam logic [COORD_W-1:0] MY_X = COORD_W'(OWN_X);
    localparam logic [COORD_W-1:0] MY_Y = COORD_W'(OWN_Y);

    function automatic logic [COORD_W-1:0] fx(input int p, input logic [NP*DATA_W-1:0] d);
        return d[p*DATA_W +: COORD_W];
    endfunction
    function automatic logic [COORD_W-1:0] fy(input int p, input logic [NP*DATA_W-1:0] d);
        return d[p*DATA_W+COORD_W +: COORD_W];
    endfunction

    genvar gp;
    generate
        for (gp = 0; gp < NP; gp++) begin : g_chk
            assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(in_ack[gp]) |-> $past(in_req[gp]));
            assert_ack_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_ack[gp] && in_req[gp] |=> in_ack[gp]);
            assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
                out_req[gp] && $past(out_req[gp]) |-> $stable(out_data[gp*DATA_W +: DATA_W]));
            assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
                out_req[gp] && out_ack[gp] |=> !out_req[gp]);
            assert_no_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !out_req[gp] && out_ack[gp] |=> !out_req[gp]);
        end
    endgenerate

    assert_east_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req[PORT_EAST]) |-> fx(PORT_EAST, out_data) > MY_X);
    assert_west_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req[PORT_WEST]) |-> fx(PORT_WEST, out_data) < MY_X);
    assert_north_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req[PORT_NORTH]) |->
            fx(PORT_NORTH, out_data) == MY_X && fy(PORT_NORTH, out_data) > MY_Y);
    assert_south_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req[PORT_SOUTH]) |->
            fx(PORT_SOUTH, out_data) == MY_X && fy(PORT_SOUTH, out_data) < MY_Y);
    assert_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req[PORT_LOCAL]) |->
            fx(PORT_LOCAL, out_data) == MY_X && fy(PORT_LOCAL, out_data) == MY_Y);
endmodule

bind mesh_xy_router mesh_xy_router_checker #(
    .DATA_W (DATA_W),
    .COORD_W(COORD_W),
    .OWN_X  (OWN_X),
    .OWN_Y  (OWN_Y),
    .NP     (NP)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_req  (in_req),
    .in_ack  (in_ack),
    .out_req (out_req),
    .out_ack (out_ack),
    .out_data(out_data)
);

// File: tb/mesh_xy_router_bench.sv
`timescale 1ns/1ps
// Bench: full destination sweep from every input, contention and back-pressure.
module mesh_xy_router_bench;
    localparam int DW = 8;
    localparam int NP = 5;
    localparam int OX = 1;
    localparam int OY = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   in_req = '0;
    logic [NP-1:0]   in_ack;
    logic [NP*DW-1:0] in_data = '0;
    logic [NP-1:0]   out_req;
    logic [NP-1:0]   out_ack = '0;
    logic [NP*DW-1:0] out_data;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mesh_xy_router #(.DATA_W(DW), .COORD_W(2), .OWN_X(OX), .OWN_Y(OY)) u_mesh_xy_router (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
        .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_dir(input int dx, input int dy);
        if (dx > OX) return 2;
        if (dx < OX) return 4;
        if (dy > OY) return 1;
        if (dy < OY) return 3;
        return 0;
    endfunction

    function automatic string dir_tag(input int d);
        case (d)
            2: return "R2 east";
            4: return "R3 west";
            1: return "R4 north";
            3: return "R5 south";
            default: return "R6 local";
        endcase
    endfunction

    // One word end to end, each result sampled on the edge it is due.
    task automatic send_one(input int p, input int dx, input int dy);
        logic [DW-1:0] w;
        int e;
        w = {4'(p * 3 + dx + dy), 2'(dy), 2'(dx)};
        e = exp_dir(dx, dy);
        @(negedge clk);
        in_req[p] = 1'b1;
        in_data[p*DW +: DW] = w;
        @(negedge clk);
        chk(in_ack[p] == 1'b1, "R7 ack rise", int'(in_ack[p]), 1);
        @(negedge clk);
        chk(out_req == NP'(1 << e), dir_tag(e), int'(out_req), 1 << e);
        chk(out_data[e*DW +: DW] == w, "R8 data", int'(out_data[e*DW +: DW]), int'(w));
        in_req[p] = 1'b0;
        @(negedge clk);
        chk(in_ack[p] == 1'b0, "R7 ack fall", int'(in_ack[p]), 0);
        out_ack[e] = 1'b1;
        @(negedge clk);
        chk(out_req[e] == 1'b0, "R9 req drop", int'(out_req[e]), 0);
        @(negedge clk);
        chk(out_req == '0, "R9 no reissue while ack high", int'(out_req), 0);
        out_ack[e] = 1'b0;
        @(negedge clk);
    endtask

    // Wait a bounded number of cycles for a given outbound request.
    task automatic wait_out(input int e, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (out_req[e]) seen = 1'b1;
        end
    endtask

    task automatic finish_out(input int e);
        out_ack[e] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        out_ack[e] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        bit seen;
        logic [DW-1:0] wa, wb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ack == '0, "R1 reset ack", int'(in_ack), 0);
        chk(out_req == '0, "R1 reset req", int'(out_req), 0);

        // Exhaustive sweep: every input, every destination of the 4x4 mesh.
        for (int p = 0; p < NP; p++)
            for (int dx = 0; dx < 4; dx++)
                for (int dy = 0; dy < 4; dy++)
                    send_one(p, dx, dy);

        // R10 round robin: input 1 served alone, then 1 and 3 contend for local.
        wa = {4'h5, 2'(OY), 2'(OX)};
        wb = {4'hA, 2'(OY), 2'(OX)};
        @(negedge clk);
        in_req[1] = 1'b1; in_data[1*DW +: DW] = wa;
        wait_out(0, seen);
        in_req[1] = 1'b0;
        finish_out(0);
        @(negedge clk);
        in_req[1] = 1'b1; in_data[1*DW +: DW] = wa;
        in_req[3] = 1'b1; in_data[3*DW +: DW] = wb;
        wait_out(0, seen);
        chk(seen && out_data[0 +: DW] == wb, "R10 rotate to input 3", int'(out_data[0 +: DW]), int'(wb));
        in_req[1] = 1'b0; in_req[3] = 1'b0;
        finish_out(0);
        wait_out(0, seen);
        chk(seen && out_data[0 +: DW] == wa, "R10 then input 1", int'(out_data[0 +: DW]), int'(wa));
        finish_out(0);

        // R11 back-pressure: held word blocks a new request on input 2.
        wa = {4'h3, 2'd0, 2'd3};
        wb = {4'hC, 2'd0, 2'd3};
        @(negedge clk);
        in_req[2] = 1'b1; in_data[2*DW +: DW] = wa;
        wait_out(2, seen);
        in_req[2] = 1'b0;
        repeat (2) @(negedge clk);
        in_req[2] = 1'b1; in_data[2*DW +: DW] = wb;
        repeat (4) @(negedge clk);
        chk(in_ack[2] == 1'b0, "R11 no ack while full", int'(in_ack[2]), 0);
        chk(out_data[2*DW +: DW] == wa, "R11 held word unchanged", int'(out_data[2*DW +: DW]), int'(wa));
        out_ack[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(in_ack[2] == 1'b1, "R11 ack after hand-off", int'(in_ack[2]), 1);
        out_ack[2] = 1'b0;
        in_req[2] = 1'b0;
        wait_out(2, seen);
        chk(seen && out_data[2*DW +: DW] == wb, "R11 second word", int'(out_data[2*DW +: DW]), int'(wb));
        finish_out(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule